// File: doc/BRIEF.md
# Serial PHY Management Controller

This block lets a host read and write the management registers of an external Ethernet PHY over the two-wire MDC/MDIO serial bus. The host sees one 32-bit command/status word. A single write of that word packs the operation, the PHY address, the register number and, for a write, the data, and it launches a complete 64-bit management frame. Reading the word back shows a busy flag, a read-valid flag and the last 16-bit value captured from the PHY.

The controller makes MDC from the system clock with a divider that is set per frame. It shifts the preamble, start, opcode, addresses and turnaround out on MDIO and then drives or samples sixteen data bits. MDIO appears as three separate pins: output, output-enable and input. The host polls busy before it issues a command. After a read it polls read-valid before it takes the data. A write needs nothing from the host after the single command write.

Top module: `mdio_ctrl`

## Requirements
- R1: Command word fields: bit 26 selects the operation (1 = read, 0 = write), bits 25:21 hold the PHY register number, bits 20:16 hold the PHY address, and bits 15:0 hold the write data. All other bits are ignored.
- R2: Every frame begins with 32 ones, then start bits 0,1, then opcode 1,0 for a read or 0,1 for a write, then the five PHY address bits and the five register bits, each field MSB first.
- R3: A write frame continues with turnaround bits 1,0 and then the 16 data bits MSB first, and output-enable stays high for all 64 bits.
- R4: A read frame drops output-enable from its 47th bit (the turnaround) to its end. The block samples MDIO on the 16 MDC rising edges of the data phase, MSB first, and shows the value in status bits 15:0.
- R5: MDC stays high for mdc_half system clocks and low for mdc_half system clocks. An mdc_half of 0 selects the default of 32, which divides the clock by 64. The value is latched when a command is accepted.
- R6: MDIO and output-enable change only in the cycle in which MDC falls, or when a frame starts.
- R7: Status bit 28 (busy) rises in the cycle after a command is accepted. It clears in the cycle in which MDC falls after the 64th bit, and MDC stays low while busy is clear.
- R8: Status bit 27 (read-valid) rises only in the cycle in which a read frame ends, and it is never set together with busy.
- R9: A command written while busy is set is ignored: the running frame, the status word and the later idle bus are unchanged.
- R10: An accepted command clears read-valid at once, and a write frame leaves it clear.
- R11: After reset the status word is zero, MDC is low and output-enable is low.
- R12: Output-enable is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | One-cycle strobe that writes the command word |
| cmd_wdata | input | 32 | Command word |
| stat_rdata | output | 32 | Status word: busy, read-valid, read data |
| mdc_half | input | HALF_W | MDC half period in system clocks, 0 selects the default |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output-enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Some rules are checked on every cycle: output-enable and MDC stay low while idle, MDIO moves only on an MDC falling edge, busy follows every accepted command, and read-valid rises only as busy falls and never overlaps it. Other rules can only be shown by the bench's scenarios. Those scenarios sweep every PHY address and register number through both write and read frames and compare each captured 64-bit frame, the output-enable pattern and the returned data with values computed arithmetically. They also measure the MDC period for several divider settings, including the default. A further scenario shows that a command issued mid-frame changes nothing.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int OP_BIT     = 26;
  localparam int REG_LSB    = 21;
  localparam int PHY_LSB    = 16;
  localparam int BUSY_BIT   = 28;
  localparam int RVAL_BIT   = 27;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] wdata;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t unpack_cmd(input logic [31:0] w);
    mgmt_cmd_t c;
    c.rd    = w[OP_BIT];
    c.regn  = w[REG_LSB +: 5];
    c.phy   = w[PHY_LSB +: 5];
    c.wdata = w[15:0];
    return c;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] d;
    op = c.rd ? 2'b10 : 2'b01;
    ta = c.rd ? 2'b00 : 2'b10;
    d  = c.rd ? 16'h0000 : c.wdata;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regn, ta, d};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_W   = 8,
  parameter int DEF_HALF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [HALF_W-1:0] half_in,
  output logic              mdc,
  output logic              rise_tick,
  output logic              fall_tick
);
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt;
  logic              wrap;

  assign wrap      = run && (cnt == half_q - 1'b1);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(DEF_HALF);
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (start) begin
      half_q <= (half_in == '0) ? HALF_W'(DEF_HALF) : half_in;
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (run) begin
      if (wrap) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
      mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_value
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx;
  logic                  is_rd;
  logic [15:0]           shreg;
  logic                  last_bit;
  logic                  in_data;
  logic                  released;

  assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
  assign in_data  = (idx >= IDX_W'(DATA_POS));
  assign released = is_rd && (idx >= IDX_W'(TA_POS));

  assign mdio_o   = frame_q[FRAME_BITS-1];
  assign mdio_oe  = busy && !released;
  assign rd_done  = busy && is_rd && fall_tick && last_bit;
  assign rd_value = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      frame_q <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      shreg   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      frame_q <= build_frame(cmd);
      idx     <= '0;
      is_rd   <= cmd.rd;
    end else if (busy) begin
      if (rise_tick && is_rd && in_data) shreg <= {shreg[14:0], mdio_i};
      if (fall_tick) begin
        frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
        if (last_bit) busy <= 1'b0;
        else          idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_W  = 8,
  parameter int DEF_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_wdata,
  output logic [31:0]       stat_rdata,
  input  logic [HALF_W-1:0] mdc_half,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int DEF_HALF = DEF_DIV / 2;

  logic        busy;
  logic        accept;
  logic        rise_tick;
  logic        fall_tick;
  logic        rd_done;
  logic [15:0] rd_value;
  logic        rvalid_q;
  logic [15:0] rd_data_q;
  mgmt_cmd_t   cmd;

  assign accept = cmd_wr && !busy;
  assign cmd    = unpack_cmd(cmd_wdata);

  mdio_clkgen #(.HALF_W(HALF_W), .DEF_HALF(DEF_HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy),
    .half_in(mdc_half), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(accept), .cmd(cmd),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done), .rd_value(rd_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q  <= 1'b0;
      rd_data_q <= '0;
    end else if (accept) begin
      rvalid_q  <= 1'b0;
    end else if (rd_done) begin
      rvalid_q  <= 1'b1;
      rd_data_q <= rd_value;
    end
  end

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[BUSY_BIT] = busy;
    stat_rdata[RVAL_BIT] = rvalid_q;
    stat_rdata[15:0]     = rd_data_q;
  end
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_wr,
  input logic busy,
  input logic rvalid,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  a_r12_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  a_r7_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r6_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));
  a_r6_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_oe != $past(mdio_oe))) |-> $fell(mdc));
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> busy);
  a_r8_rvalid_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $fell(busy));
  a_r8_rvalid_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rvalid);
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(busy), .rvalid(rvalid_q),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_ctrl_tb.sv
module mdio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] stat_rdata;
  logic [7:0]  mdc_half = 8'd1;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int          n_chk = 0;
  int          n_err = 0;
  bit          finished = 0;
  bit          mon_clr = 0;
  int          nrise = 0;
  int          gap = 0;
  int          gap_err = 0;
  int          exp_gap = 2;
  logic        mdc_prev = 1'b0;
  logic [63:0] cap_f = '0;
  logic [63:0] cap_oe = '0;
  logic [15:0] phy_val = '0;

  always #10 clk = ~clk;

  mdio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .stat_rdata(stat_rdata), .mdc_half(mdc_half), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = (nrise >= 48 && nrise < 64) ? phy_val[63 - nrise] : 1'b1;

  always @(negedge clk) begin
    if (mon_clr) begin
      nrise = 0; gap = 0; gap_err = 0; cap_f = '0; cap_oe = '0;
    end else begin
      gap = gap + 1;
      if (mdc && !mdc_prev) begin
        cap_f  = {cap_f[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        if (nrise > 0 && gap != exp_gap) gap_err = gap_err + 1;
        nrise = nrise + 1;
        gap = 0;
      end
    end
    mdc_prev = mdc;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {5'b0, rd, r, p, d};
  endfunction

  task automatic launch(input logic [31:0] w);
    mon_clr = 1;
    @(negedge clk); @(negedge clk);
    mon_clr = 0;
    cmd_wr = 1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 0;
    chk(stat_rdata[28] == 1'b1, "R7 busy after accept", 64'(stat_rdata[28]), 64'd1);
    chk(stat_rdata[27] == 1'b0, "R10 rvalid cleared", 64'(stat_rdata[27]), 64'd0);
  endtask

  task automatic finish_frame();
    while (stat_rdata[28]) @(negedge clk);
  endtask

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [63:0] ef;
    ef = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    launch(mk_cmd(1'b0, p, r, d));
    finish_frame();
    chk(cap_f == ef && nrise == 64, "R2 R3 write frame", cap_f, ef);
    chk(cap_oe == '1, "R3 write oe", cap_oe, '1);
    chk(gap_err == 0, "R5 mdc period", 64'(gap_err), 64'd0);
    chk(stat_rdata[27] == 1'b0, "R10 write leaves rvalid clear", 64'(stat_rdata[27]), 64'd0);
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] v);
    logic [45:0] eh;
    logic [63:0] eoe;
    eh  = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    eoe = {{46{1'b1}}, 18'b0};
    phy_val = v;
    launch(mk_cmd(1'b1, p, r, ~v));
    finish_frame();
    chk(cap_f[63:18] == eh, "R1 R2 read header", 64'(cap_f[63:18]), 64'(eh));
    chk(cap_oe == eoe, "R4 read oe", cap_oe, eoe);
    chk(stat_rdata == {3'b0, 1'b0, 1'b1, 11'b0, v}, "R4 R8 read result",
        64'(stat_rdata), 64'({3'b0, 1'b0, 1'b1, 11'b0, v}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] last;
    repeat (3) @(negedge clk);
    chk(stat_rdata == 32'h0, "R11 reset status", 64'(stat_rdata), 64'd0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R11 reset pins", {62'd0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mdc_half = 8'd1; exp_gap = 2;
    for (int p = 0; p < 32; p++) begin
      do_write(5'(p), 5'(31 - p), 16'(p * 16'h0841) ^ 16'hA5C3);
      do_read(5'(p), 5'(p ^ 5), 16'(p * 16'h1357) ^ 16'h3C96);
      chk(mdio_oe == 1'b0 && mdc == 1'b0, "R12 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
    end
    for (int h = 2; h <= 4; h++) begin
      mdc_half = 8'(h); exp_gap = 2 * h;
      do_write(5'(h), 5'(h * 3), 16'(h * 16'h1111));
      do_read(5'(h + 9), 5'(h * 7), 16'(16'hF00F >> h));
    end
    mdc_half = 8'd0; exp_gap = 64;
    do_write(5'd17, 5'd10, 16'hBEEF);
    mdc_half = 8'd1; exp_gap = 2;
    do_read(5'd3, 5'd4, 16'h5AA5);
    last = 16'h5AA5;
    // R10: a write clears read-valid; R9: a read issued mid-frame is ignored
    launch(mk_cmd(1'b0, 5'd9, 5'd22, 16'h1234));
    repeat (20) @(negedge clk);
    cmd_wr = 1; cmd_wdata = mk_cmd(1'b1, 5'd1, 5'd2, 16'h0);
    @(negedge clk);
    cmd_wr = 0;
    chk(stat_rdata[28] == 1'b1 && stat_rdata[27] == 1'b0, "R9 status unchanged",
        64'(stat_rdata[28:27]), 64'd2);
    finish_frame();
    chk(cap_f == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd22, 2'b10, 16'h1234} && nrise == 64,
        "R9 frame unchanged", cap_f, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd22, 2'b10, 16'h1234});
    repeat (40) @(negedge clk);
    chk(nrise == 64 && stat_rdata == {16'h0, last}, "R9 no extra frame",
        {32'(nrise), stat_rdata}, {32'd64, 16'h0, last});
    // R1: bits outside the fields are ignored
    launch(32'hF800_0000 | mk_cmd(1'b0, 5'd5, 5'd6, 16'h00FF));
    finish_frame();
    chk(cap_f == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h00FF},
        "R1 spare bits ignored", cap_f, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h00FF});
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule